// File: doc/BRIEF.md
# First/Next Error Logger

This block collects error pulses from a bus-bridge unit. Each source drives a one-cycle pulse on its own bit of an 8-bit input. The first unmasked error, or a group of errors that arrive together while nothing is logged yet, is kept in a capture register. Every error that comes after it is added to an accumulating register that uses the same bit positions.

A mask register stops a source from being logged and from raising an interrupt. Software reads the registers through a small read/write port and clears error bits by writing ones to them. Two level outputs report whether any fatal or any non-fatal error is logged.

Two resets are provided. The power-on reset clears everything. A warm reset keeps all logged errors and the mask. During a warm reset the read data is forced to zero and register writes are ignored.

Error bit positions, used by the input, all error registers and the mask:

| Bit | Source | Class |
|-----|--------|-------|
| 0 | address/command parity | fatal |
| 1 | illegal access | fatal |
| 2 | internal parity | non-fatal |
| 3 | out-of-range address | fatal |
| 4 | reserved | none |
| 5 | configuration access error | non-fatal |
| 6 | target abort | fatal |
| 7 | reserved | none |

Register addresses:

| Address | Register |
|---------|----------|
| 50h | capture register |
| 52h | accumulating register |
| 54h | mask register |

Top module: `err_logger`

## Requirements
- R1: While `por_n` is low, the capture register (50h), the accumulating register (52h) and the mask register (54h) all clear to 00h, and `rd_data` and both interrupt outputs are 0.
- R2: When the capture register is 00h, every unmasked error pulse seen on that clock edge sets its bit in the capture register. The pulse is not recorded in the accumulating register.
- R3: While the capture register is non-zero, it holds its value. Unmasked error pulses are ORed into the accumulating register instead, so several of its bits can be set at once.
- R4: A source whose mask bit (54h) is 1 is logged in neither error register and raises no interrupt. A mask bit of 0 enables the source.
- R5: A write to 50h or 52h clears every bit written as 1. Bits written as 0 keep their value. A write to 54h loads the mask.
- R6: If an error is logged into a register on the same edge that a write clears that bit, the bit ends up set.
- R7: `irq_fatal` is 1 exactly when a fatal bit (0, 1, 3 or 6) is set in either error register. `irq_nonfatal` does the same for the non-fatal bits (2 and 5).
- R8: While `warm_rst_n` is low, all three registers keep their contents and error capture goes on. Register writes are ignored and `rd_data` reads 0.
- R9: Bits 4 and 7 are never set in any register, and input pulses on them are ignored. Reads of any address other than 50h, 52h or 54h return 00h.
- R10: `rd_data` shows the addressed register one cycle after `rd_en` is sampled high. It holds its value while `rd_en` is low.
- R11: Once software clears the capture register to 00h, the next unmasked error is captured there again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous |
| err_in | input | 8 | One-cycle error pulses, one bit per source |
| reg_addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data (bits written as 1 clear error bits) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq_fatal | output | 1 | A fatal error is logged |
| irq_nonfatal | output | 1 | A non-fatal error is logged |

## Verification
An error pulse and a software write-one-to-clear can land on the same edge. The bench provokes this in three ways:
- on a bit of the accumulating register that is already set;
- on the capture register while it is still holding an error, so the new pulse must move to the accumulating register;
- on the capture register after it was just emptied, so the pulse must be captured there.

The driver performs the write and the pulse on the same cycle. The scoreboard then reads back both registers and compares them with values worked out from R2, R3 and R6.

// File: rtl/err_logger_pkg.sv
package err_logger_pkg;
  localparam int REG_W = 8;
  typedef logic [REG_W-1:0] reg_t;

  // bit classes: fatal 0,1,3,6 ; non-fatal 2,5 ; reserved 4,7
  localparam reg_t SRC_IMPL     = 8'h6F;
  localparam reg_t FATAL_SET    = 8'h4B;
  localparam reg_t NONFATAL_SET = 8'h24;

  // clear-by-one then set; a set on the same edge wins
  function automatic reg_t w1c_merge(reg_t cur, reg_t clr, reg_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic class_any(reg_t bits, reg_t cls);
    return |(bits & cls);
  endfunction

  function automatic reg_t route_pick(logic take, reg_t bits);
    return take ? bits : '0;
  endfunction
endpackage

// File: rtl/err_logger_mask.sv
module err_logger_mask
  import err_logger_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic load,
  input  reg_t load_val,
  output reg_t mask_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     mask_q <= '0;
    else if (load)  mask_q <= load_val & SRC_IMPL;
  end

  assert_mask_rsvd_R9: assert property (@(posedge clk) disable iff (!por_n)
    (mask_q & ~SRC_IMPL) == '0);

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
    !load |=> $stable(mask_q));
endmodule

// File: rtl/err_logger_capture.sv
module err_logger_capture
  import err_logger_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  reg_t err_in,
  input  reg_t mask_q,
  input  reg_t clr_first,
  input  reg_t clr_next,
  output reg_t first_q,
  output reg_t next_q,
  output reg_t hit
);
  logic first_empty;
  reg_t to_first, to_next;

  assign hit         = err_in & ~mask_q & SRC_IMPL;
  assign first_empty = (first_q == '0);
  assign to_first    = route_pick(first_empty, hit);
  assign to_next     = route_pick(!first_empty, hit);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      first_q <= '0;
      next_q  <= '0;
    end else begin
      first_q <= w1c_merge(first_q, clr_first, to_first);
      next_q  <= w1c_merge(next_q, clr_next, to_next);
    end
  end

  assert_first_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    (first_q != '0 && clr_first == '0) |=> first_q == $past(first_q));

  assert_masked_unlogged_R4: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> (((first_q & ~$past(first_q)) | (next_q & ~$past(next_q))) & $past(mask_q)) == '0);

  assert_hit_kept_R6: assert property (@(posedge clk) disable iff (!por_n)
    (hit != '0) |=> ((first_q | next_q) & $past(hit)) == $past(hit));

  assert_empty_capture_R2: assert property (@(posedge clk) disable iff (!por_n)
    (first_empty && hit != '0) |=> first_q == $past(hit));
endmodule

// File: rtl/err_logger_readout.sv
module err_logger_readout
  import err_logger_pkg::*;
#(
  parameter int   ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FIRST_ADR = 8'h50,
  parameter logic [ADDR_W-1:0] NEXT_ADR  = 8'h52,
  parameter logic [ADDR_W-1:0] MASK_ADR  = 8'h54
)(
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  reg_t              first_q,
  input  reg_t              next_q,
  input  reg_t              mask_q,
  output reg_t              rd_data
);
  reg_t sel;

  always_comb begin
    unique case (addr)
      FIRST_ADR: sel = first_q;
      NEXT_ADR:  sel = next_q;
      MASK_ADR:  sel = mask_q;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           rd_data <= '0;
    else if (!warm_rst_n) rd_data <= '0;
    else if (rd_en)       rd_data <= sel;
  end

  assert_warm_rd_zero_R8: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> rd_data == '0);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst_n && !rd_en) |=> $stable(rd_data));
endmodule

// File: rtl/err_logger.sv
module err_logger
  import err_logger_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] FIRST_ADR = 8'h50,
  parameter logic [ADDR_W-1:0] NEXT_ADR  = 8'h52,
  parameter logic [ADDR_W-1:0] MASK_ADR  = 8'h54
)(
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic [7:0]        err_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              irq_fatal,
  output logic              irq_nonfatal
);
  logic wr_ok, mask_load;
  reg_t clr_first, clr_next, first_q, next_q, mask_q, hit, logged;

  // writes are ignored during warm reset
  assign wr_ok     = wr_en && warm_rst_n;
  assign mask_load = wr_ok && (reg_addr == MASK_ADR);
  assign clr_first = (wr_ok && reg_addr == FIRST_ADR) ? wr_data : '0;
  assign clr_next  = (wr_ok && reg_addr == NEXT_ADR)  ? wr_data : '0;

  err_logger_mask u_mask (
    .clk(clk), .por_n(por_n), .load(mask_load), .load_val(wr_data), .mask_q(mask_q)
  );

  err_logger_capture u_cap (
    .clk(clk), .por_n(por_n), .err_in(err_in), .mask_q(mask_q),
    .clr_first(clr_first), .clr_next(clr_next),
    .first_q(first_q), .next_q(next_q), .hit(hit)
  );

  err_logger_readout #(
    .ADDR_W(ADDR_W), .FIRST_ADR(FIRST_ADR), .NEXT_ADR(NEXT_ADR), .MASK_ADR(MASK_ADR)
  ) u_rd (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .rd_en(rd_en), .addr(reg_addr),
    .first_q(first_q), .next_q(next_q), .mask_q(mask_q), .rd_data(rd_data)
  );

  assign logged       = first_q | next_q;
  assign irq_fatal    = class_any(logged, FATAL_SET);
  assign irq_nonfatal = class_any(logged, NONFATAL_SET);

  assert_rsvd_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
    (logged & ~SRC_IMPL) == '0);

  assert_fatal_cause_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(irq_fatal) |-> ($past(hit) & FATAL_SET) != '0);

  assert_nonfatal_cause_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(irq_nonfatal) |-> ($past(hit) & NONFATAL_SET) != '0);

  assert_warm_keep_R8: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> ((logged & $past(logged)) == $past(logged)) && $stable(mask_q));
endmodule

// File: tb/err_logger_bench.sv
module err_logger_bench;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, warm_rst_n = 1'b1;
  logic [7:0] err_in = '0, reg_addr = '0, wr_data = '0, rd_data;
  logic       wr_en = 1'b0, rd_en = 1'b0, irq_fatal, irq_nonfatal;
  logic       rd_pend = 1'b0;
  int         n_run = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [7:0] A_F = 8'h50, A_N = 8'h52, A_M = 8'h54;

  always #10 clk = ~clk;  // 50 MHz

  err_logger u_err_logger (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .err_in(err_in),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq_fatal(irq_fatal), .irq_nonfatal(irq_nonfatal)
  );

  always @(posedge clk) rd_pend <= rd_en;

  // monitor: pops the expected read result one cycle after the read
  always @(negedge clk) begin
    if (rd_pend) begin
      logic [7:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      n_run++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s: rd_data=%02h expected=%02h", t, rd_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); err_in = e;
    @(negedge clk); err_in = '0;
  endtask

  task automatic wr_and_pulse(input logic [7:0] a, input logic [7:0] d, input logic [7:0] e);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wr_data = d; err_in = e;
    @(negedge clk); wr_en = 1'b0; err_in = '0;
  endtask

  task automatic chk_irq(input logic f, input logic nf, input string t);
    n_run++;
    if (irq_fatal !== f || irq_nonfatal !== nf) begin
      n_fail++;
      $display("FAIL %s: irq f/nf=%b%b expected=%b%b", t, irq_fatal, irq_nonfatal, f, nf);
    end
  endtask

  task automatic clear_all();
    wr(A_F, 8'hFF); wr(A_N, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_irq(0, 0, "R1 irq in reset");
    por_n = 1'b1;
    rd(A_F, 8'h00, "R1 first after por");
    rd(A_N, 8'h00, "R1 next after por");
    rd(A_M, 8'h00, "R1 mask after por");

    pulse(8'h02);
    rd(A_F, 8'h02, "R2 first capture");
    rd(A_N, 8'h00, "R2 next untouched");
    chk_irq(1, 0, "R7 fatal only");

    pulse(8'h04);
    pulse(8'h01);
    rd(A_N, 8'h05, "R3 next accumulates");
    rd(A_F, 8'h02, "R3 first held");
    chk_irq(1, 1, "R7 both classes");

    wr(A_N, 8'h01);
    rd(A_N, 8'h04, "R5 w1c clears one");
    wr(A_F, 8'h00);
    rd(A_F, 8'h02, "R5 write zero keeps");
    wr(A_F, 8'h02);
    rd(A_F, 8'h00, "R5 first cleared");
    chk_irq(0, 1, "R7 nonfatal only");

    pulse(8'h08);
    rd(A_F, 8'h08, "R11 recapture");
    rd(A_N, 8'h04, "R11 next unchanged");
    chk_irq(1, 1, "R7 out-of-range fatal");

    clear_all();
    chk_irq(0, 0, "R7 all clear");
    pulse(8'h21);
    rd(A_F, 8'h21, "R2 simultaneous errors");
    rd(A_N, 8'h00, "R2 simultaneous not in next");

    wr(A_M, 8'hFF);
    rd(A_M, 8'h6F, "R9 mask reserved bits");
    pulse(8'h6F);
    rd(A_F, 8'h21, "R4 masked first");
    rd(A_N, 8'h00, "R4 masked next");
    clear_all();
    pulse(8'h44);
    chk_irq(0, 0, "R4 masked no irq");
    rd(A_F, 8'h00, "R4 masked not captured");
    wr(A_M, 8'h40);
    pulse(8'h44);
    rd(A_F, 8'h04, "R4 partial mask");
    wr(A_M, 8'h00);
    clear_all();

    pulse(8'h90);
    rd(A_F, 8'h00, "R9 reserved input first");
    rd(A_N, 8'h00, "R9 reserved input next");
    rd(8'h56, 8'h00, "R9 unmapped address");
    rd(8'h51, 8'h00, "R9 odd address");

    // collisions of logging and clearing
    pulse(8'h01);
    pulse(8'h04);
    wr_and_pulse(A_N, 8'h04, 8'h04);
    rd(A_N, 8'h04, "R6 next clear vs set");
    wr_and_pulse(A_F, 8'h01, 8'h01);
    rd(A_F, 8'h00, "R6 first cleared, pulse routed");
    rd(A_N, 8'h05, "R6 pulse went to next");
    clear_all();
    wr_and_pulse(A_F, 8'hFF, 8'h02);
    rd(A_F, 8'h02, "R6 empty first clear vs set");

    // read hold
    @(negedge clk); reg_addr = A_M;
    @(negedge clk);
    n_run++;
    if (rd_data !== 8'h02) begin
      n_fail++; $display("FAIL R10 hold: rd_data=%02h expected=02", rd_data);
    end

    // warm reset
    clear_all();
    pulse(8'h01);
    pulse(8'h04);
    wr(A_M, 8'h20);
    @(negedge clk); warm_rst_n = 1'b0;
    wr(A_F, 8'hFF);
    wr(A_M, 8'h00);
    pulse(8'h08);
    rd(A_F, 8'h00, "R8 rd zero in warm");
    @(negedge clk); warm_rst_n = 1'b1;
    rd(A_F, 8'h01, "R8 first kept");
    rd(A_N, 8'h0C, "R8 next kept and captured");
    rd(A_M, 8'h20, "R8 mask kept");
    chk_irq(1, 1, "R8 irq kept");

    @(negedge clk); por_n = 1'b0;
    @(negedge clk);
    n_run++;
    if (rd_data !== 8'h00) begin
      n_fail++; $display("FAIL R1 rd in por: rd_data=%02h expected=00", rd_data);
    end
    chk_irq(0, 0, "R1 irq after por");
    por_n = 1'b1;
    rd(A_F, 8'h00, "R1 first cleared by por");
    rd(A_N, 8'h00, "R1 next cleared by por");
    rd(A_M, 8'h00, "R1 mask cleared by por");

    repeat (2) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++; $display("FAIL scoreboard: left=%0d expected=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule